// File: doc/BRIEF.md
# Layered Gene-Drop Inbreeding Estimator

This block holds a fixed pedigree in hardware and runs one gene-drop sample of the whole pedigree on every clock cycle. Each founder always carries two allele labels that appear nowhere else. Each descendant is a small processor of its own. On every clock it takes one allele from its sire and one from its dam, and a meiosis bit from its own pseudo-random source picks which of the parent's two alleles it takes. Individuals sit in generation layers, so a new pair moves one layer down on each clock. When a parent is more than one layer above its child, a holder chain delays the parent's pair. The child then combines alleles that belong to the same sample.

Each descendant counts the samples in which its two alleles carry the same label. Because the founder labels are unique, a match means the two alleles are identical by descent. The inbreeding coefficient F of an individual is its match count divided by the global sample count. Software starts a run, stops it after enough samples, and reads each count through a simple index-and-read port. The pedigree is a constant table in the package, with parents listed before their children.

Top module: `gene_drop_inbreed`

## Requirements
- R1: After reset, `sample_count` is 0, `active` is 0 and every individual reads a count of 0.
- R2: Founder k holds the fixed labels 2k and 2k+1, so a founder never counts a match and always reads 0.
- R3: Each descendant takes one allele of its sire and one of its dam, each chosen by its own meiosis bit. Over about 65536 samples, every F comes within 0.02 of its pedigree coancestry value (parent-offspring mating gives 0.25), and a child of two unrelated founders reads exactly 0.
- R4: A parent two or more layers above a child reaches it through holder stages that keep the same sample together. The child of individual 3 and its own offspring 4 gives F = 0.375 within 0.02.
- R5: A start clears the counts. The fill then lasts MAX_LAYER cycles (3 for the default pedigree). After that, `sample_count` rises by exactly one per cycle, so k-1 cycles after the start edge it reads max(0, k-4).
- R6: The sample counter and every match counter saturate at 2^CNT_W-1 and never wrap. No match count exceeds the sample count.
- R7: A stop freezes all counts and drops `active`. A start clears all counts and restarts the fill, and start wins when start and stop are asserted in the same cycle.
- R8: `rd_count` shows, with no clock delay, the match count of the individual selected by `rd_idx`. Indices at or above NUM_IND read 0.
- R9: `active` is high exactly in the cycles in which samples are being counted (run on and fill complete).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Clear all counts and begin a run |
| stop | input | 1 | End the run and freeze all counts |
| rd_idx | input | RD_W (4) | Individual selected for readout |
| rd_count | output | CNT_W | Match count of the selected individual |
| sample_count | output | CNT_W | Number of samples counted in this run |
| active | output | 1 | High while samples are being counted |

## Verification
The bench computes the coancestry matrix of the pedigree on its own and compares every measured F with it. The skipped-generation individual is the key case: if its holder stage is missing, sire and offspring alleles come from different samples and its F falls to 0.25 instead of 0.375. Probes at random points in the fill catch an off-by-one fill delay, which shows up as a sample count one too high or one too low. A narrow-counter instance runs far past its limit, so a counter that wraps reads a small value instead of 63. Start-and-stop in the same cycle, a frozen count after stop, and reads past the last individual are each checked at the ports.

// File: rtl/ged_pkg.sv
`timescale 1ns/1ps
package ged_pkg;

    // Pedigree table: parents listed before children, -1 marks a founder.
    localparam int NUM_IND = 8;
    localparam int SIRE_OF [NUM_IND] = '{-1, -1, -1, 0, 0, 3, 4, 3};
    localparam int DAM_OF  [NUM_IND] = '{-1, -1, -1, 1, 3, 2, 5, 4};

    localparam int LBL_W = $clog2(2 * NUM_IND);
    localparam int RD_W  = $clog2(NUM_IND + 1);
    localparam int RNG_W = 16;
    localparam logic [RNG_W-1:0] RNG_POLY = 16'hB400;

    typedef struct packed {
        logic [LBL_W-1:0] a;
        logic [LBL_W-1:0] b;
    } pair_t;

    function automatic bit is_founder(int k);
        return SIRE_OF[k] < 0;
    endfunction

    function automatic int layer_of(int k);
        int lay [NUM_IND];
        for (int i = 0; i < NUM_IND; i++) begin
            if (SIRE_OF[i] < 0) lay[i] = 0;
            else if (lay[SIRE_OF[i]] > lay[DAM_OF[i]]) lay[i] = lay[SIRE_OF[i]] + 1;
            else lay[i] = lay[DAM_OF[i]] + 1;
        end
        return lay[k];
    endfunction

    function automatic int deepest_layer();
        int m = 0;
        for (int i = 0; i < NUM_IND; i++)
            if (layer_of(i) > m) m = layer_of(i);
        return m;
    endfunction

    localparam int MAX_LAYER = deepest_layer();

    // Holder stages between parent p and child c.
    function automatic int delay_from(int p, int c);
        if (is_founder(p)) return 0;
        return layer_of(c) - 1 - layer_of(p);
    endfunction

    // Distinct nonzero seed per meiosis source.
    function automatic logic [RNG_W-1:0] seed_of(int k);
        logic [31:0] v;
        logic [RNG_W-1:0] s;
        v = k * 40503 + 12345;
        s = v[RNG_W-1:0] ^ 16'hACE1;
        if (s == '0) s = 16'h0001;
        return s;
    endfunction

endpackage

// File: rtl/ged_lfsr.sv
`timescale 1ns/1ps
module ged_lfsr #(
    parameter int W = 16,
    parameter logic [W-1:0] POLY = '1,
    parameter logic [W-1:0] SEED = 1
) (
    input  logic clk,
    input  logic rst,
    output logic bit_o
);
    logic [W-1:0] st;

    always_ff @(posedge clk) begin
        if (rst) st <= SEED;
        else if (st[0]) st <= (st >> 1) ^ POLY;
        else st <= st >> 1;
    end

    assign bit_o = st[0];

    // R3: the meiosis source never locks up in the all-zero state
    p_rng_live_r3: assert property (@(posedge clk) disable iff (rst) st != '0);

endmodule

// File: rtl/ged_holder.sv
`timescale 1ns/1ps
module ged_holder import ged_pkg::*; #(
    parameter int DEPTH = 1
) (
    input  logic  clk,
    input  logic  rst,
    input  pair_t din,
    output pair_t dout
);
    pair_t stage [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
        end else begin
            stage[0] <= din;
            for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
        end
    end

    assign dout = stage[DEPTH-1];

endmodule

// File: rtl/ged_node.sv
`timescale 1ns/1ps
module ged_node import ged_pkg::*; #(
    parameter int CNT_W = 20,
    parameter int SIRE_DLY = 0,
    parameter int DAM_DLY = 0,
    parameter logic [RNG_W-1:0] SIRE_SEED = 16'h0001,
    parameter logic [RNG_W-1:0] DAM_SEED = 16'h0002
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             cnt_en,
    input  pair_t            sire_pair,
    input  pair_t            dam_pair,
    output pair_t            pair_q,
    output logic [CNT_W-1:0] match_cnt
);
    pair_t sire_use, dam_use;
    logic  sel_s, sel_d;

    ged_lfsr #(.W(RNG_W), .POLY(RNG_POLY), .SEED(SIRE_SEED)) u_rng_s (
        .clk(clk), .rst(rst), .bit_o(sel_s));
    ged_lfsr #(.W(RNG_W), .POLY(RNG_POLY), .SEED(DAM_SEED)) u_rng_d (
        .clk(clk), .rst(rst), .bit_o(sel_d));

    generate
        if (SIRE_DLY > 0) begin : g_hold_s
            ged_holder #(.DEPTH(SIRE_DLY)) u_hold (
                .clk(clk), .rst(rst), .din(sire_pair), .dout(sire_use));
        end else begin : g_pass_s
            assign sire_use = sire_pair;
        end
        if (DAM_DLY > 0) begin : g_hold_d
            ged_holder #(.DEPTH(DAM_DLY)) u_hold (
                .clk(clk), .rst(rst), .din(dam_pair), .dout(dam_use));
        end else begin : g_pass_d
            assign dam_use = dam_pair;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            pair_q <= '0;
        end else begin
            pair_q.a <= sel_s ? sire_use.b : sire_use.a;
            pair_q.b <= sel_d ? dam_use.b : dam_use.a;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) match_cnt <= '0;
        else if (cnt_en && (pair_q.a == pair_q.b) && (match_cnt != '1))
            match_cnt <= match_cnt + 1'b1;
    end

    // R3: each allele is one of the two the parent offered one cycle earlier
    p_allele_sire_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pair_q.a == $past(sire_use.a) || pair_q.a == $past(sire_use.b)));
    p_allele_dam_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pair_q.b == $past(dam_use.a) || pair_q.b == $past(dam_use.b)));
    // R6: match counter moves by at most one and holds at its ceiling
    p_cnt_step_r6: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (match_cnt - $past(match_cnt)) <= CNT_W'(1));
    p_cnt_sat_r6: assert property (@(posedge clk) disable iff (rst)
        (match_cnt == '1 && !clr) |=> match_cnt == '1);

endmodule

// File: rtl/gene_drop_inbreed.sv
`timescale 1ns/1ps
module gene_drop_inbreed import ged_pkg::*; #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             stop,
    input  logic [RD_W-1:0]  rd_idx,
    output logic [CNT_W-1:0] rd_count,
    output logic [CNT_W-1:0] sample_count,
    output logic             active
);
    localparam int FILL_W = $clog2(MAX_LAYER + 1);

    logic              run;
    logic [FILL_W-1:0] fill;
    logic [CNT_W-1:0]  samp;
    logic              counting;

    assign counting = run && (fill == FILL_W'(MAX_LAYER));

    always_ff @(posedge clk) begin
        if (rst) begin
            run  <= 1'b0;
            fill <= '0;
            samp <= '0;
        end else if (start) begin
            run  <= 1'b1;
            fill <= '0;
            samp <= '0;
        end else begin
            if (stop) run <= 1'b0;
            if (run && fill != FILL_W'(MAX_LAYER)) fill <= fill + 1'b1;
            if (counting && samp != '1) samp <= samp + 1'b1;
        end
    end

    pair_t            pair_q [NUM_IND];
    logic [CNT_W-1:0] cnt_q  [NUM_IND];

    generate
        for (genvar k = 0; k < NUM_IND; k++) begin : g_ind
            if (is_founder(k)) begin : g_fnd
                assign pair_q[k] = '{a: LBL_W'(2 * k), b: LBL_W'(2 * k + 1)};
                assign cnt_q[k]  = '0;
            end else begin : g_dsc
                ged_node #(
                    .CNT_W(CNT_W),
                    .SIRE_DLY(delay_from(SIRE_OF[k], k)),
                    .DAM_DLY(delay_from(DAM_OF[k], k)),
                    .SIRE_SEED(seed_of(2 * k)),
                    .DAM_SEED(seed_of(2 * k + 1))
                ) u_node (
                    .clk(clk), .rst(rst), .clr(start), .cnt_en(counting),
                    .sire_pair(pair_q[SIRE_OF[k]]), .dam_pair(pair_q[DAM_OF[k]]),
                    .pair_q(pair_q[k]), .match_cnt(cnt_q[k]));

                // R6: no individual can record more matches than samples taken
                p_match_bound_r6: assert property (@(posedge clk) disable iff (rst)
                    cnt_q[k] <= samp);
            end
        end
    endgenerate

    always_comb begin
        rd_count = '0;
        for (int i = 0; i < NUM_IND; i++)
            if (rd_idx == RD_W'(i)) rd_count = cnt_q[i];
    end

    assign sample_count = samp;
    assign active = counting;

    // R5: no sample is counted outside the counting window
    p_fill_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (!counting && !start) |=> $stable(samp));
    // R5: one sample per cycle once filled
    p_samp_step_r5: assert property (@(posedge clk) disable iff (rst)
        (counting && !start && samp != '1) |=> samp == $past(samp) + 1'b1);
    // R7: start clears and reopens the fill
    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        start |=> (samp == '0 && !counting));
    // R7: stop alone ends counting
    p_stop_freeze_r7: assert property (@(posedge clk) disable iff (rst)
        (stop && !start) |=> !counting);

endmodule

// File: tb/test_gene_drop_inbreed.sv
`timescale 1ns/1ps
module test_gene_drop_inbreed;
    import ged_pkg::*;

    localparam int CW = 20;
    localparam int SW = 6;
    localparam int RUN_SAMPLES = 65536;
    localparam real TOL = 0.02;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic stop = 1'b0;
    logic [RD_W-1:0] rd_idx = '0;
    logic [CW-1:0] rd_count, sample_count;
    logic active;

    logic sat_start = 1'b0;
    logic [SW-1:0] sat_rd, sat_samples;
    logic sat_active;

    int n_chk = 0;
    int n_bad = 0;

    real kin [NUM_IND][NUM_IND];
    real fexp [NUM_IND];
    longint got_cnt [NUM_IND];

    always #2 clk = ~clk;

    gene_drop_inbreed #(.CNT_W(CW)) i_gene_drop_inbreed (
        .clk(clk), .rst(rst), .start(start), .stop(stop), .rd_idx(rd_idx),
        .rd_count(rd_count), .sample_count(sample_count), .active(active));

    gene_drop_inbreed #(.CNT_W(SW)) i_gene_drop_inbreed_sat (
        .clk(clk), .rst(rst), .start(sat_start), .stop(1'b0), .rd_idx(RD_W'(4)),
        .rd_count(sat_rd), .sample_count(sat_samples), .active(sat_active));

    task automatic chk(input string req, input longint got, input longint exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic chk_real(input string req, input real got, input real exp);
        n_chk++;
        if (got > exp + TOL || got < exp - TOL) begin
            n_bad++;
            $display("FAIL %s: got %f expected %f", req, got, exp);
        end
    endtask

    // Coancestry of the pedigree, built generation by generation.
    task automatic build_expect();
        for (int j = 0; j < NUM_IND; j++) begin
            if (SIRE_OF[j] < 0) begin
                fexp[j] = 0.0;
                for (int i = 0; i < j; i++) begin
                    kin[i][j] = 0.0;
                    kin[j][i] = 0.0;
                end
            end else begin
                fexp[j] = kin[SIRE_OF[j]][DAM_OF[j]];
                for (int i = 0; i < j; i++) begin
                    kin[i][j] = 0.5 * (kin[i][SIRE_OF[j]] + kin[i][DAM_OF[j]]);
                    kin[j][i] = kin[i][j];
                end
            end
            kin[j][j] = 0.5 * (1.0 + fexp[j]);
        end
    endtask

    task automatic read_cnt(input int idx, output longint v);
        rd_idx = RD_W'(idx);
        #1;
        v = rd_count;
    endtask

    // Start, then sample k-1 cycles after the start edge.
    task automatic fill_probe(input int k);
        longint exp_cnt;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (k - 1) @(negedge clk);
        exp_cnt = (k - 1 > 3) ? k - 4 : 0;
        chk($sformatf("R5 fill probe k=%0d", k), sample_count, exp_cnt);
        chk($sformatf("R9 active k=%0d", k), active, (k - 1 >= 3) ? 1 : 0);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #800000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        longint v, s_total;
        int guard;
        void'($urandom(32'd4051));
        build_expect();

        repeat (3) @(negedge clk);
        chk("R1 sample_count after reset", sample_count, 0);
        chk("R9 active after reset", active, 0);
        for (int i = 0; i < NUM_IND; i++) begin
            read_cnt(i, v);
            chk($sformatf("R1 count of %0d after reset", i), v, 0);
        end
        @(negedge clk) rst = 1'b0;
        sat_start = 1'b1;
        @(negedge clk) sat_start = 1'b0;

        // R5 directed edges of the fill, then random depths
        fill_probe(4);
        fill_probe(5);
        for (int n = 0; n < 3; n++) fill_probe($urandom_range(6, 40));

        // R7 start and stop together: start wins and the run proceeds
        @(negedge clk) begin start = 1'b1; stop = 1'b1; end
        @(negedge clk) begin start = 1'b0; stop = 1'b0; end
        repeat (5) @(negedge clk);
        chk("R7 start over stop count", sample_count, 2);
        chk("R7 start over stop active", active, 1);

        // Main run
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        guard = 0;
        while (sample_count < RUN_SAMPLES && guard < 150000) begin
            @(negedge clk);
            guard++;
        end
        stop = 1'b1;
        @(negedge clk) stop = 1'b0;
        s_total = sample_count;
        repeat (8) @(negedge clk);
        chk("R7 sample_count frozen after stop", sample_count, s_total);
        chk("R9 active low after stop", active, 0);
        chk("R5 enough samples gathered", (s_total >= RUN_SAMPLES) ? 1 : 0, 1);

        for (int i = 0; i < NUM_IND; i++) read_cnt(i, got_cnt[i]);
        for (int i = 0; i < NUM_IND; i++) begin
            if (SIRE_OF[i] < 0)
                chk($sformatf("R2 founder %0d count", i), got_cnt[i], 0);
            else
                chk_real($sformatf("R3 F of individual %0d", i),
                         real'(got_cnt[i]) / real'(s_total), fexp[i]);
        end
        chk("R3 child of unrelated founders exact", got_cnt[3], 0);
        chk("R3 child of layer-1 and founder exact", got_cnt[5], 0);
        chk_real("R3 parent-offspring mating", real'(got_cnt[4]) / real'(s_total), 0.25);
        chk_real("R4 skipped-generation mating", real'(got_cnt[7]) / real'(s_total), 0.375);

        // R8 random readout order, including indices past the pedigree
        for (int n = 0; n < 16; n++) begin
            int idx;
            idx = $urandom_range(0, (1 << RD_W) - 1);
            read_cnt(idx, v);
            chk($sformatf("R8 readout idx %0d", idx), v, (idx < NUM_IND) ? got_cnt[idx] : 0);
        end
        read_cnt(NUM_IND, v);
        chk("R8 first index past end", v, 0);

        // R6 narrow instance has run far beyond its ceiling
        chk("R6 sample counter saturated", sat_samples, (1 << SW) - 1);
        chk("R6 match counter saturated", sat_rd, (1 << SW) - 1);
        repeat (4) @(negedge clk);
        chk("R6 sample counter holds", sat_samples, (1 << SW) - 1);

        // R7 a new start clears every count
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        read_cnt(7, v);
        chk("R7 start clears counts", v, 0);
        chk("R7 start clears samples", sample_count, 0);

        finish_run();
    end

endmodule